// File: doc/BRIEF.md
# Channel Command Stream Parser

This block turns a serial stream of 32-bit command words into register writes and control events for a host DMA engine that programs client units. Each word arrives on a valid/ready handshake. A word that arrives while no data is pending is a header. The block decodes the header's opcode from bits [31:28], pulls out its fields, and works out how many data words belong to it. Each following data word then leaves as a write, tagged with a register offset and the current class.

Besides writes, headers can change the current class, the stored payload, the application ID or the stream ID. They can also announce a gather (address and count only; no memory fetch), request a restart at a new address, or acquire and release a module lock. Error pulses report unknown opcodes, unknown extend sub-opcodes, and wide-count writes issued while the payload is still invalid.

Every result appears on the outputs exactly one clock after the word that caused it is accepted.

Top module: `cmd_stream_parser`

## Requirements
- R1: The opcode is header bits [31:28]. Code 0xF pulses `errUnknown` for one cycle and consumes no data. Every output pulse and every register change appears in the cycle after the causing word is accepted.
- R2: Opcode 0x0 loads class = bits [15:6] and base offset = bits [27:16], with mask = bits [5:0]. It is then followed by popcount(mask) data words. Each goes to base + the index of the next set mask bit, lowest bit first. A zero mask means no data words.
- R3: Opcode 0x1 (auto-increment) and 0x2 (fixed) take offset = bits [27:16] and count = bits [15:0]. Auto-increment writes offset, offset+1, and so on. Fixed writes every word to the same offset. A zero count means the next word is a header.
- R4: Opcode 0x3 takes offset = bits [27:16] and mask = bits [15:0]. It is followed by popcount(mask) data words, each sent to offset + the next set bit index, ascending.
- R5: Opcode 0x4 makes one write with offset = bits [27:16] and data = bits [15:0] zero-extended. No data words follow.
- R6: Opcode 0x5 pulses `restartValid` with address = bits [27:0] shifted left by 4. Opcode 0xD is followed by one word, which becomes the restart address.
- R7: Opcode 0x6 latches offset [27:16], insert flag [15], type flag [14] and count [13:0]. Opcode 0xC latches count [15:0] and clears offset and both flags. In both cases the next word is the gather address and pulses `gatherValid`.
- R8: The payload register resets to 0xFFFFFFFF, which means invalid. Opcode 0x9 loads it with bits [15:0] zero-extended.
- R9: Opcodes 0xA (auto-increment) and 0xB (fixed) take offset = bits [21:0] and take the data-word count from payload bits [15:0]. A zero payload means no data. An invalid payload pulses `errPayload`, and no data words follow.
- R10: For opcode 0xE, the sub-opcode is bits [27:24]. Sub-opcode 0 pulses `lockAcquire` and 1 pulses `lockRelease`, each with lock index = bits [7:0]. Any other sub-opcode pulses `errExtend`.
- R11: Opcode 0x8 sets the application ID from bits [7:0]. Opcode 0x7 sets the stream ID from bits [23:0].
- R12: While data words are pending, every accepted word is data, whatever its top nibble. Each write carries the current class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Command word valid |
| inWord | input | 32 | Command word |
| inReady | output | 1 | Word accepted when high with inValid; high from the first edge after reset |
| wrValid | output | 1 | Register write pulse |
| wrOffset | output | 22 | Write target offset |
| wrData | output | 32 | Write data |
| wrClass | output | 10 | Class in force for the write |
| gatherValid | output | 1 | Gather announced |
| gatherAddr | output | 32 | Gather address |
| gatherCount | output | 16 | Gather word count |
| gatherOffset | output | 12 | Gather offset |
| gatherInsert | output | 1 | Gather insert flag |
| gatherType | output | 1 | Gather type flag |
| restartValid | output | 1 | Restart requested |
| restartAddr | output | 32 | Restart address |
| lockAcquire | output | 1 | Module lock acquire pulse |
| lockRelease | output | 1 | Module lock release pulse |
| lockIndex | output | 8 | Lock index |
| curClass | output | 10 | Current class |
| payload | output | 32 | Stored payload |
| appId | output | 8 | Application ID |
| streamId | output | 24 | Stream ID |
| errUnknown | output | 1 | Unknown opcode pulse |
| errExtend | output | 1 | Unknown extend sub-opcode pulse |
| errPayload | output | 1 | Wide-count write with invalid payload |

## Verification
The assertions check the following on every cycle:
- at most one event pulse fires at a time;
- no pulse appears without a word accepted in the previous cycle;
- an unknown-opcode error traces back to a 0xF top nibble;
- class and payload hold while no word is accepted;
- a stored valid payload never has its upper half set;
- a payload error only occurs while the payload is invalid;
- lock pulses carry the low byte of the causing word.

Only the bench's scenarios can show the following:
- that mask popcounts, auto-increment and fixed offsets produce the right write sequences;
- that a word with an opcode-like top nibble is still treated as data while a count is pending;
- that zero counts and zero masks return straight to header decode.

// File: rtl/parser_pkg.sv
`timescale 1ns/1ps
package parser_pkg;
  parameter int WORD_W  = 32;
  parameter int NOFF_W  = 12;
  parameter int WOFF_W  = 22;
  parameter int CLASS_W = 10;
  parameter int CNT_W   = 16;
  parameter int APP_W   = 8;
  parameter int STRM_W  = 24;
  parameter int LOCK_W  = 8;
  parameter int GCNT_W  = 16;
  parameter int SMASK_W = 6;
  parameter int MASK_W  = 16;
  localparam int IDX_W  = $clog2(MASK_W);
  localparam logic [WORD_W-1:0] PAYLOAD_INVALID = '1;

  typedef enum logic [3:0] {
    OP_SETCLASS  = 4'h0, OP_INCR      = 4'h1, OP_NONINCR   = 4'h2,
    OP_MASK      = 4'h3, OP_IMM       = 4'h4, OP_RESTART   = 4'h5,
    OP_GATHER    = 4'h6, OP_SETSTRM   = 4'h7, OP_SETAPP    = 4'h8,
    OP_SETPYLD   = 4'h9, OP_INCR_W    = 4'hA, OP_NONINCR_W = 4'hB,
    OP_GATHER_W  = 4'hC, OP_RESTART_W = 4'hD, OP_EXTEND    = 4'hE
  } opcode_e;

  typedef enum logic [2:0] {
    PH_HEADER, PH_INCR, PH_FIXED, PH_MASK, PH_GADDR, PH_RADDR
  } phase_e;

  typedef struct packed {
    logic ldClass;
    logic ldOffNarrow;
    logic ldOffWide;
    logic ldMaskSetcl;
    logic ldMaskFull;
    logic ldPayload;
    logic ldApp;
    logic ldStream;
    logic ldGather;
    logic ldGatherW;
    logic wrImm;
    logic wrIncr;
    logic wrFixed;
    logic wrMask;
    logic fireGather;
    logic fireRestart;
    logic fireRestartW;
    logic lockAcq;
    logic lockRel;
    logic errUnk;
    logic errExt;
    logic errPay;
  } strobe_t;
endpackage

// File: rtl/parser_ctrl.sv
`timescale 1ns/1ps
module parser_ctrl
  import parser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] payloadVal,
  output strobe_t           stb
);
  phase_e           phase, phaseNext;
  logic [CNT_W-1:0] remaining, remNext;
  opcode_e          op;
  logic [3:0]       subOp;
  logic [CNT_W-1:0] setclCount, maskCount;

  assign op         = opcode_e'(word[31:28]);
  assign subOp      = word[27:24];
  assign setclCount = CNT_W'($countones(word[SMASK_W-1:0]));
  assign maskCount  = CNT_W'($countones(word[MASK_W-1:0]));

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    remNext   = remaining;
    if (accept) begin
      if (phase == PH_HEADER) begin
        case (op)
          OP_SETCLASS: begin
            stb.ldClass = 1'b1; stb.ldOffNarrow = 1'b1; stb.ldMaskSetcl = 1'b1;
            if (setclCount != '0) begin phaseNext = PH_MASK; remNext = setclCount; end
          end
          OP_INCR, OP_NONINCR: begin
            stb.ldOffNarrow = 1'b1;
            if (word[CNT_W-1:0] != '0) begin
              phaseNext = (op == OP_INCR) ? PH_INCR : PH_FIXED;
              remNext   = word[CNT_W-1:0];
            end
          end
          OP_MASK: begin
            stb.ldOffNarrow = 1'b1; stb.ldMaskFull = 1'b1;
            if (maskCount != '0) begin phaseNext = PH_MASK; remNext = maskCount; end
          end
          OP_IMM:       stb.wrImm = 1'b1;
          OP_RESTART:   stb.fireRestart = 1'b1;
          OP_GATHER: begin
            stb.ldGather = 1'b1; phaseNext = PH_GADDR; remNext = CNT_W'(1);
          end
          OP_SETSTRM:   stb.ldStream = 1'b1;
          OP_SETAPP:    stb.ldApp = 1'b1;
          OP_SETPYLD:   stb.ldPayload = 1'b1;
          OP_INCR_W, OP_NONINCR_W: begin
            stb.ldOffWide = 1'b1;
            if (payloadVal == PAYLOAD_INVALID) stb.errPay = 1'b1;
            else if (payloadVal[CNT_W-1:0] != '0) begin
              phaseNext = (op == OP_INCR_W) ? PH_INCR : PH_FIXED;
              remNext   = payloadVal[CNT_W-1:0];
            end
          end
          OP_GATHER_W: begin
            stb.ldGatherW = 1'b1; phaseNext = PH_GADDR; remNext = CNT_W'(1);
          end
          OP_RESTART_W: begin phaseNext = PH_RADDR; remNext = CNT_W'(1); end
          OP_EXTEND: begin
            if (subOp == 4'h0)      stb.lockAcq = 1'b1;
            else if (subOp == 4'h1) stb.lockRel = 1'b1;
            else                    stb.errExt  = 1'b1;
          end
          default: stb.errUnk = 1'b1;
        endcase
      end else begin
        case (phase)
          PH_INCR:  stb.wrIncr       = 1'b1;
          PH_FIXED: stb.wrFixed      = 1'b1;
          PH_MASK:  stb.wrMask       = 1'b1;
          PH_GADDR: stb.fireGather   = 1'b1;
          PH_RADDR: stb.fireRestartW = 1'b1;
          default: ;
        endcase
        remNext = remaining - CNT_W'(1);
        if (remaining == CNT_W'(1)) phaseNext = PH_HEADER;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_HEADER;
      remaining <= '0;
    end else begin
      phase     <= phaseNext;
      remaining <= remNext;
    end
  end
endmodule

// File: rtl/parser_datapath.sv
`timescale 1ns/1ps
module parser_datapath
  import parser_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            stb,
  input  logic [WORD_W-1:0]  word,
  output logic               wrValid,
  output logic [WOFF_W-1:0]  wrOffset,
  output logic [WORD_W-1:0]  wrData,
  output logic [CLASS_W-1:0] wrClass,
  output logic               gatherValid,
  output logic [WORD_W-1:0]  gatherAddr,
  output logic [GCNT_W-1:0]  gatherCount,
  output logic [NOFF_W-1:0]  gatherOffset,
  output logic               gatherInsert,
  output logic               gatherType,
  output logic               restartValid,
  output logic [WORD_W-1:0]  restartAddr,
  output logic               lockAcquire,
  output logic               lockRelease,
  output logic [LOCK_W-1:0]  lockIndex,
  output logic [CLASS_W-1:0] curClass,
  output logic [WORD_W-1:0]  payload,
  output logic [APP_W-1:0]   appId,
  output logic [STRM_W-1:0]  streamId,
  output logic               errUnknown,
  output logic               errExtend,
  output logic               errPayload
);
  logic [WOFF_W-1:0] offReg;
  logic [MASK_W-1:0] maskReg;
  logic [IDX_W-1:0]  lowIdx;

  always_comb begin
    lowIdx = '0;
    for (int i = MASK_W - 1; i >= 0; i--)
      if (maskReg[i]) lowIdx = IDX_W'(i);
  end

  // Field registers updated by header strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offReg       <= '0;
      maskReg      <= '0;
      curClass     <= '0;
      payload      <= PAYLOAD_INVALID;
      appId        <= '0;
      streamId     <= '0;
      gatherCount  <= '0;
      gatherOffset <= '0;
      gatherInsert <= 1'b0;
      gatherType   <= 1'b0;
    end else begin
      if (stb.ldOffNarrow)    offReg <= WOFF_W'(word[27:16]);
      else if (stb.ldOffWide) offReg <= word[WOFF_W-1:0];
      else if (stb.wrIncr)    offReg <= offReg + WOFF_W'(1);
      if (stb.ldMaskSetcl)     maskReg <= MASK_W'(word[SMASK_W-1:0]);
      else if (stb.ldMaskFull) maskReg <= word[MASK_W-1:0];
      else if (stb.wrMask)     maskReg <= maskReg & (maskReg - MASK_W'(1));
      if (stb.ldClass)   curClass <= word[15:6];
      if (stb.ldPayload) payload  <= WORD_W'(word[15:0]);
      if (stb.ldApp)     appId    <= word[APP_W-1:0];
      if (stb.ldStream)  streamId <= word[STRM_W-1:0];
      if (stb.ldGather) begin
        gatherOffset <= word[27:16];
        gatherInsert <= word[15];
        gatherType   <= word[14];
        gatherCount  <= GCNT_W'(word[13:0]);
      end else if (stb.ldGatherW) begin
        gatherOffset <= '0;
        gatherInsert <= 1'b0;
        gatherType   <= 1'b0;
        gatherCount  <= word[GCNT_W-1:0];
      end
    end
  end

  // Output pulses and their payloads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrValid      <= 1'b0;
      wrOffset     <= '0;
      wrData       <= '0;
      wrClass      <= '0;
      gatherValid  <= 1'b0;
      gatherAddr   <= '0;
      restartValid <= 1'b0;
      restartAddr  <= '0;
      lockAcquire  <= 1'b0;
      lockRelease  <= 1'b0;
      lockIndex    <= '0;
      errUnknown   <= 1'b0;
      errExtend    <= 1'b0;
      errPayload   <= 1'b0;
    end else begin
      wrValid      <= stb.wrImm | stb.wrIncr | stb.wrFixed | stb.wrMask;
      gatherValid  <= stb.fireGather;
      restartValid <= stb.fireRestart | stb.fireRestartW;
      lockAcquire  <= stb.lockAcq;
      lockRelease  <= stb.lockRel;
      errUnknown   <= stb.errUnk;
      errExtend    <= stb.errExt;
      errPayload   <= stb.errPay;
      if (stb.wrImm) begin
        wrOffset <= WOFF_W'(word[27:16]);
        wrData   <= WORD_W'(word[15:0]);
        wrClass  <= curClass;
      end else if (stb.wrIncr | stb.wrFixed | stb.wrMask) begin
        wrOffset <= stb.wrMask ? offReg + WOFF_W'(lowIdx) : offReg;
        wrData   <= word;
        wrClass  <= curClass;
      end
      if (stb.fireGather)        gatherAddr  <= word;
      if (stb.fireRestart)       restartAddr <= {word[27:0], 4'b0000};
      else if (stb.fireRestartW) restartAddr <= word;
      if (stb.lockAcq | stb.lockRel) lockIndex <= word[LOCK_W-1:0];
    end
  end
endmodule

// File: rtl/cmd_stream_parser.sv
`timescale 1ns/1ps
module cmd_stream_parser
  import parser_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [WORD_W-1:0]  inWord,
  output logic               inReady,
  output logic               wrValid,
  output logic [WOFF_W-1:0]  wrOffset,
  output logic [WORD_W-1:0]  wrData,
  output logic [CLASS_W-1:0] wrClass,
  output logic               gatherValid,
  output logic [WORD_W-1:0]  gatherAddr,
  output logic [GCNT_W-1:0]  gatherCount,
  output logic [NOFF_W-1:0]  gatherOffset,
  output logic               gatherInsert,
  output logic               gatherType,
  output logic               restartValid,
  output logic [WORD_W-1:0]  restartAddr,
  output logic               lockAcquire,
  output logic               lockRelease,
  output logic [LOCK_W-1:0]  lockIndex,
  output logic [CLASS_W-1:0] curClass,
  output logic [WORD_W-1:0]  payload,
  output logic [APP_W-1:0]   appId,
  output logic [STRM_W-1:0]  streamId,
  output logic               errUnknown,
  output logic               errExtend,
  output logic               errPayload
);
  strobe_t stb;
  logic    readyQ;
  logic    accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readyQ <= 1'b0;
    else        readyQ <= 1'b1;
  end

  assign inReady = readyQ;
  assign accept  = inValid & readyQ;

  parser_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .word(inWord),
    .payloadVal(payload), .stb(stb)
  );

  parser_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .word(inWord),
    .wrValid(wrValid), .wrOffset(wrOffset), .wrData(wrData), .wrClass(wrClass),
    .gatherValid(gatherValid), .gatherAddr(gatherAddr), .gatherCount(gatherCount),
    .gatherOffset(gatherOffset), .gatherInsert(gatherInsert), .gatherType(gatherType),
    .restartValid(restartValid), .restartAddr(restartAddr),
    .lockAcquire(lockAcquire), .lockRelease(lockRelease), .lockIndex(lockIndex),
    .curClass(curClass), .payload(payload), .appId(appId), .streamId(streamId),
    .errUnknown(errUnknown), .errExtend(errExtend), .errPayload(errPayload)
  );
endmodule

// File: rtl/parser_checker.sv
`timescale 1ns/1ps
module parser_checker
  import parser_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic [WORD_W-1:0]  inWord,
  input logic               inReady,
  input logic               wrValid,
  input logic               gatherValid,
  input logic               restartValid,
  input logic               lockAcquire,
  input logic               lockRelease,
  input logic [LOCK_W-1:0]  lockIndex,
  input logic [CLASS_W-1:0] curClass,
  input logic [WORD_W-1:0]  payload,
  input logic               errUnknown,
  input logic               errExtend,
  input logic               errPayload
);
  logic anyEvent;
  assign anyEvent = wrValid | gatherValid | restartValid | lockAcquire |
                    lockRelease | errUnknown | errExtend | errPayload;

  a_r1_unknown_src: assert property (@(posedge clk) disable iff (!rst_n)
    errUnknown |-> $past(inValid && inReady && inWord[31:28] == 4'hF));

  a_r1_event_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    anyEvent |-> $past(inValid && inReady));

  a_r12_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrValid, gatherValid, restartValid, lockAcquire, lockRelease,
              errUnknown, errExtend, errPayload}));

  a_r8_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inValid && inReady) |-> $stable(payload));

  a_r8_payload_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (payload != PAYLOAD_INVALID) |-> (payload[31:16] == 16'h0));

  a_r2_class_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inValid && inReady) |-> $stable(curClass));

  a_r9_payload_err: assert property (@(posedge clk) disable iff (!rst_n)
    errPayload |-> (payload == PAYLOAD_INVALID));

  a_r10_lock_index: assert property (@(posedge clk) disable iff (!rst_n)
    (lockAcquire || lockRelease) |-> (lockIndex == $past(inWord[LOCK_W-1:0])));
endmodule

bind cmd_stream_parser parser_checker u_checker (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inWord(inWord), .inReady(inReady),
  .wrValid(wrValid), .gatherValid(gatherValid), .restartValid(restartValid),
  .lockAcquire(lockAcquire), .lockRelease(lockRelease), .lockIndex(lockIndex),
  .curClass(curClass), .payload(payload), .errUnknown(errUnknown),
  .errExtend(errExtend), .errPayload(errPayload)
);

// File: tb/tb_cmd_stream_parser.sv
`timescale 1ns/1ps
module tb_cmd_stream_parser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic inReady, wrValid, gatherValid, gatherInsert, gatherType, restartValid;
  logic lockAcquire, lockRelease, errUnknown, errExtend, errPayload;
  logic [21:0] wrOffset;
  logic [31:0] wrData, gatherAddr, restartAddr, payload;
  logic [9:0]  wrClass, curClass;
  logic [15:0] gatherCount;
  logic [11:0] gatherOffset;
  logic [7:0]  lockIndex, appId;
  logic [23:0] streamId;

  cmd_stream_parser dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string curReq = "R8", eReq = "R8";

  // Reference model state (reset values)
  logic eReady = 0, eWr = 0, eGv = 0, eGins = 0, eGtyp = 0, eRv = 0;
  logic eAcq = 0, eRel = 0, eErrU = 0, eErrE = 0, eErrP = 0;
  logic [21:0] eOff = 0;
  logic [31:0] eData = 0, eGaddr = 0, eRaddr = 0, ePay = 32'hFFFF_FFFF;
  logic [9:0]  eWcls = 0, eCls = 0;
  logic [15:0] eGcnt = 0;
  logic [11:0] eGoff = 0;
  logic [7:0]  eIdx = 0, eApp = 0;
  logic [23:0] eStrm = 0;
  int pend[$];   // pending data words: offset, -1 gather address, -2 restart address

  always @(posedge clk) begin
    eReq = curReq;
    if (!rst_n) begin
      eReady = 0; eWr = 0; eGv = 0; eRv = 0; eAcq = 0; eRel = 0;
      eErrU = 0; eErrE = 0; eErrP = 0; ePay = 32'hFFFF_FFFF; pend.delete();
    end else begin
      logic acc;
      acc = inValid && eReady;
      eReady = 1;
      eWr = 0; eGv = 0; eRv = 0; eAcq = 0; eRel = 0; eErrU = 0; eErrE = 0; eErrP = 0;
      if (acc) begin
        if (pend.size() > 0) begin
          int k;
          k = pend.pop_front();
          if (k == -1) begin eGv = 1; eGaddr = inWord; end
          else if (k == -2) begin eRv = 1; eRaddr = inWord; end
          else begin eWr = 1; eOff = 22'(k); eData = inWord; eWcls = eCls; end
        end else begin
          int base, n;
          base = int'(inWord[27:16]);
          case (inWord[31:28])
            4'h0: begin
              eCls = inWord[15:6];
              for (int b = 0; b < 6; b++) if (inWord[b]) pend.push_back(base + b);
            end
            4'h1: for (int i = 0; i < int'(inWord[15:0]); i++) pend.push_back(base + i);
            4'h2: for (int i = 0; i < int'(inWord[15:0]); i++) pend.push_back(base);
            4'h3: for (int b = 0; b < 16; b++) if (inWord[b]) pend.push_back(base + b);
            4'h4: begin eWr = 1; eOff = 22'(base); eData = {16'h0, inWord[15:0]}; eWcls = eCls; end
            4'h5: begin eRv = 1; eRaddr = inWord << 4; end
            4'h6: begin
              eGoff = inWord[27:16]; eGins = inWord[15]; eGtyp = inWord[14];
              eGcnt = {2'b00, inWord[13:0]}; pend.push_back(-1);
            end
            4'h7: eStrm = inWord[23:0];
            4'h8: eApp = inWord[7:0];
            4'h9: ePay = {16'h0, inWord[15:0]};
            4'hA, 4'hB: begin
              if (ePay == 32'hFFFF_FFFF) eErrP = 1;
              else begin
                n = int'(ePay[15:0]);
                for (int i = 0; i < n; i++)
                  pend.push_back(int'(inWord[21:0]) + ((inWord[31:28] == 4'hA) ? i : 0));
              end
            end
            4'hC: begin
              eGoff = 0; eGins = 0; eGtyp = 0; eGcnt = inWord[15:0]; pend.push_back(-1);
            end
            4'hD: pend.push_back(-2);
            4'hE: begin
              if (inWord[27:24] == 4'h0) begin eAcq = 1; eIdx = inWord[7:0]; end
              else if (inWord[27:24] == 4'h1) begin eRel = 1; eIdx = inWord[7:0]; end
              else eErrE = 1;
            end
            default: eErrU = 1;
          endcase
        end
      end
    end
  end

  task automatic chk(input string field, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", eReq, field, act, exp, cycles);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    chk("inReady", 64'(inReady), 64'(eReady));
    chk("wrValid", 64'(wrValid), 64'(eWr));
    if (eWr) begin
      chk("wrOffset", 64'(wrOffset), 64'(eOff));
      chk("wrData", 64'(wrData), 64'(eData));
      chk("wrClass", 64'(wrClass), 64'(eWcls));
    end
    chk("gatherValid", 64'(gatherValid), 64'(eGv));
    if (eGv) chk("gatherAddr", 64'(gatherAddr), 64'(eGaddr));
    chk("gatherFields", {gatherCount, gatherOffset, gatherInsert, gatherType},
        {eGcnt, eGoff, eGins, eGtyp});
    chk("restartValid", 64'(restartValid), 64'(eRv));
    if (eRv) chk("restartAddr", 64'(restartAddr), 64'(eRaddr));
    chk("lockPulses", {lockAcquire, lockRelease}, {eAcq, eRel});
    if (eAcq || eRel) chk("lockIndex", 64'(lockIndex), 64'(eIdx));
    chk("curClass", 64'(curClass), 64'(eCls));
    chk("payload", 64'(payload), 64'(ePay));
    chk("appId", 64'(appId), 64'(eApp));
    chk("streamId", 64'(streamId), 64'(eStrm));
    chk("errors", {errUnknown, errExtend, errPayload}, {eErrU, eErrE, eErrP});
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic put(input logic [31:0] w, input string req);
    @(negedge clk);
    inValid = 1'b1; inWord = w; curReq = req;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inWord = 32'h5A5A_5A5A; curReq = req;
    end
  endtask

  initial begin
    idle(3, "R8");
    rst_n = 1'b1;
    idle(2, "R8");
    // R9: wide write while payload still invalid
    put(32'hA000_0010, "R9");
    put(32'h8000_007C, "R11");
    put(32'h70AB_CDEF, "R11");
    // R2: class 0x2A, offset 0x010, mask 0x25 -> offsets 0x10, 0x12, 0x15
    put(32'h0010_0AA5, "R2");
    put(32'h1111_1111, "R2");
    idle(1, "R2");
    put(32'h2222_2222, "R2");
    put(32'h3333_3333, "R2");
    put(32'h0007_5540, "R2");  // zero mask, class 0x155
    put(32'h4055_BEEF, "R5");
    // R3 and R12: auto-increment with opcode-like data words
    put(32'h1020_0003, "R3");
    put(32'hF000_0000, "R12");
    put(32'hAAAA_0001, "R12");
    put(32'hE100_0000, "R12");
    put(32'h2030_0002, "R3");
    put(32'h0000_0005, "R3");
    idle(2, "R3");
    put(32'h0000_0006, "R3");
    put(32'h1040_0000, "R3");  // zero count
    put(32'h8000_0011, "R3");
    // R4: mask 0x8001 -> offsets 0x100, 0x10F
    put(32'h3100_8001, "R4");
    put(32'h0000_000A, "R4");
    put(32'h0000_000B, "R4");
    // R6
    put(32'h5123_4567, "R6");
    put(32'hD000_0000, "R6");
    put(32'h1357_9BDF, "R6");
    // R7
    put(32'h60AB_8123, "R7");
    put(32'h8000_1000, "R7");
    put(32'h6FFF_7FFF, "R7");
    put(32'h0000_0004, "R7");
    put(32'hC000_4567, "R7");
    put(32'h9000_0000, "R7");
    // R8 and R9: payload then wide writes
    put(32'h9000_0002, "R8");
    put(32'hA012_3456, "R9");
    put(32'h0000_0001, "R9");
    put(32'h0000_0002, "R9");
    put(32'hB03F_FFFF, "R9");
    put(32'h0000_0003, "R9");
    put(32'h0000_0004, "R9");
    put(32'h9000_0000, "R8");
    put(32'hA000_0001, "R9");  // zero payload, no data
    // R10
    put(32'hE000_0003, "R10");
    put(32'hE100_0003, "R10");
    put(32'hE500_0009, "R10");
    // R1
    put(32'hF000_0000, "R1");
    put(32'hFFFF_FFFF, "R1");
    idle(4, "R1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule